// File: doc/BRIEF.md
# Peripheral-to-Flash Address Translation Table

This block turns peripheral bus addresses into flash byte addresses. It holds a table of 192 entries. Each entry covers a run of 16 KiB regions of the peripheral address space, with a run length that is a power of two. The entry sends that run to consecutive flash blocks, starting at a block number that software chooses. Each entry has its own CPU enable, its own DMA enable, and a marker saying that the initialization vector stands in for flash data.

Software programs an entry in two steps. First it writes a staging register with the run-size exponent, the two enables and the vector marker. Then it writes the entry's own word, holding the flash block and the base region. That second write commits the entry, copying in whatever configuration is staged at that moment.

A lookup presents an address and a request type. One cycle later the block answers with a hit flag, the flash byte address and the vector marker. When several entries match, the entry with the lowest index wins.

Top module: `atb_xlate`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and `rsp_valid`, `rsp_hit`, `rsp_iv` and `rsp_addr` are all 0.
- R2: A pulse on `stg_wr` stages four fields from `stg_data`: bit 8 is the vector marker, bit 5 the CPU enable, bit 4 the DMA enable, and bits 3:0 the run exponent n. Staging alone leaves every committed entry unchanged.
- R3: A pulse on `ent_wr` with `ent_idx` below 192 commits that entry. The entry takes its flash block from `ent_data[31:16]`, its base region from `ent_data[15:0]`, and the fields currently staged. Committing again overwrites the entry. A commit with an index of 192 or more has no effect.
- R4: The region of a lookup is `lk_addr[29:14]`. Bits 31:30 of the address are ignored. An entry with exponent n matches when region>>n equals base>>n, so the base bits below n are treated as zero.
- R5: A CPU lookup (`lk_dma`=0) matches only entries whose CPU enable is set. A DMA lookup (`lk_dma`=1) matches only entries whose DMA enable is set.
- R6: On a hit, `rsp_addr` equals (block + (region mod 2^n)) × 0x4000 + `lk_addr[13:0]`.
- R7: When several entries match, the one with the lowest index supplies the response.
- R8: On a hit, `rsp_iv` carries the vector marker of the winning entry.
- R9: On a miss, `rsp_hit`=0, `rsp_addr`=0 and `rsp_iv`=0.
- R10: `rsp_valid` is high in the cycle after each cycle in which `lk_req` is high, and low otherwise. The response reflects the table as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_wr | input | 1 | Write strobe for the staging register |
| stg_data | input | 32 | Staging word: marker, enables, exponent |
| ent_wr | input | 1 | Entry commit strobe |
| ent_idx | input | 8 | Index of the entry to commit |
| ent_data | input | 32 | Flash block [31:16], base region [15:0] |
| lk_req | input | 1 | Lookup request |
| lk_dma | input | 1 | Request type: 1 = DMA, 0 = CPU |
| lk_addr | input | 32 | Peripheral address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_iv | output | 1 | The winning entry uses the initialization vector |
| rsp_addr | output | 30 | Translated flash byte address |

## Verification
The properties assume the following about the inputs:
- `lk_req` is a clean level sampled at each edge.
- `lk_addr` is held steady only within the request cycle; the offset check compares against its value in that cycle.

The table-empty property counts every commit strobe as a possible table change, including strobes with an out-of-range index, so it stays safe whatever index the bench drives.

The bench keeps to this contract:
- It drives all inputs on the falling edge and holds each strobe for exactly one cycle.
- It never overlaps a commit with a lookup. The ordering between commits and responses is therefore unambiguous.

// File: rtl/atb_xlate.sv
module atb_xlate #(
  parameter int N_ENT = 192,
  parameter int BLK_W = 16,
  parameter int RGN_W = 16,
  parameter int OFS_W = 14,
  parameter int LG_W  = 4,
  localparam int IDX_W = 8,
  localparam int FA_W  = BLK_W + OFS_W,
  localparam int PA_W  = RGN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_wr,
  input  logic [31:0]      stg_data,
  input  logic             ent_wr,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [31:0]      ent_data,
  input  logic             lk_req,
  input  logic             lk_dma,
  input  logic [31:0]      lk_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_iv,
  output logic [FA_W-1:0]  rsp_addr
);

  logic            stg_iv, stg_cpu, stg_dma;
  logic [LG_W-1:0] stg_lg;

  logic            e_vld [N_ENT];
  logic            e_cpu [N_ENT];
  logic            e_dma [N_ENT];
  logic            e_iv  [N_ENT];
  logic [LG_W-1:0]  e_lg   [N_ENT];
  logic [BLK_W-1:0] e_blk  [N_ENT];
  logic [RGN_W-1:0] e_base [N_ENT];

  logic [N_ENT-1:0] hit_v;
  logic [BLK_W-1:0] xblk [N_ENT];
  logic [RGN_W-1:0] lk_rgn;
  logic             idx_ok;
  logic             sel_hit, sel_iv;
  logic [BLK_W-1:0] sel_blk;

  assign lk_rgn = lk_addr[PA_W-1:OFS_W];
  assign idx_ok = {1'b0, ent_idx} < (IDX_W+1)'(N_ENT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_iv  <= 1'b0;
      stg_cpu <= 1'b0;
      stg_dma <= 1'b0;
      stg_lg  <= '0;
    end else if (stg_wr) begin
      stg_iv  <= stg_data[8];
      stg_cpu <= stg_data[5];
      stg_dma <= stg_data[4];
      stg_lg  <= stg_data[LG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) e_vld[i] <= 1'b0;
    end else if (ent_wr && idx_ok) begin
      e_vld[ent_idx]  <= 1'b1;
      e_cpu[ent_idx]  <= stg_cpu;
      e_dma[ent_idx]  <= stg_dma;
      e_iv[ent_idx]   <= stg_iv;
      e_lg[ent_idx]   <= stg_lg;
      e_blk[ent_idx]  <= ent_data[31:16];
      e_base[ent_idx] <= ent_data[RGN_W-1:0];
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [RGN_W-1:0] msk;
    assign msk      = ~({RGN_W{1'b1}} << e_lg[g]);
    assign hit_v[g] = e_vld[g] && (lk_dma ? e_dma[g] : e_cpu[g]) &&
                      ((lk_rgn & ~msk) == (e_base[g] & ~msk));
    assign xblk[g]  = e_blk[g] + BLK_W'(lk_rgn & msk);
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_iv  = 1'b0;
    sel_blk = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        sel_hit = 1'b1;
        sel_iv  = e_iv[i];
        sel_blk = xblk[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_iv    <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && sel_hit;
      rsp_iv    <= lk_req && sel_hit && sel_iv;
      rsp_addr  <= (lk_req && sel_hit) ? {sel_blk, lk_addr[OFS_W-1:0]} : '0;
    end
  end

endmodule

// File: rtl/atb_xlate_chk.sv
module atb_xlate_chk #(
  parameter int OFS_W = 14,
  parameter int FA_W  = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ent_wr,
  input logic            lk_req,
  input logic [31:0]     lk_addr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_iv,
  input logic [FA_W-1:0] rsp_addr
);

  logic any_wr;
  always_ff @(posedge clk) begin
    if (!rst_n) any_wr <= 1'b0;
    else if (ent_wr) any_wr <= 1'b1;
  end

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  a_r9_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && !rsp_iv));
  a_r1_empty_table_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !any_wr) |-> !rsp_hit);
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_addr[OFS_W-1:0] == $past(lk_addr[OFS_W-1:0]));
  a_r8_iv_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_iv |-> rsp_hit);

endmodule

bind atb_xlate atb_xlate_chk #(.OFS_W(OFS_W), .FA_W(FA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_wr(ent_wr), .lk_req(lk_req), .lk_addr(lk_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_iv(rsp_iv), .rsp_addr(rsp_addr)
);

// File: tb/atb_xlate_test.sv
module atb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stg_wr = 1'b0, ent_wr = 1'b0, lk_req = 1'b0, lk_dma = 1'b0;
  logic [31:0] stg_data = '0, ent_data = '0, lk_addr = '0;
  logic [7:0]  ent_idx = '0;
  logic        rsp_valid, rsp_hit, rsp_iv;
  logic [29:0] rsp_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  atb_xlate uut (
    .clk(clk), .rst_n(rst_n), .stg_wr(stg_wr), .stg_data(stg_data),
    .ent_wr(ent_wr), .ent_idx(ent_idx), .ent_data(ent_data),
    .lk_req(lk_req), .lk_dma(lk_dma), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_iv(rsp_iv), .rsp_addr(rsp_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic stage(input bit iv, input bit cpu, input bit dma, input logic [3:0] lg);
    @(negedge clk);
    stg_wr = 1'b1;
    stg_data = {23'b0, iv, 2'b0, cpu, dma, lg};
    @(negedge clk);
    stg_wr = 1'b0;
  endtask

  task automatic commit(input logic [7:0] idx, input logic [15:0] blk, input logic [15:0] base);
    @(negedge clk);
    ent_wr = 1'b1;
    ent_idx = idx;
    ent_data = {blk, base};
    @(negedge clk);
    ent_wr = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a, input bit dma,
                      input bit ehit, input logic [29:0] eaddr, input bit eiv);
    @(negedge clk);
    lk_req = 1'b1;
    lk_dma = dma;
    lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_hit", 32'(rsp_hit), 32'(ehit));
    chk(req, "rsp_addr", 32'(rsp_addr), 32'(eaddr));
    chk(req, "rsp_iv", 32'(rsp_iv), 32'(eiv));
  endtask

  task automatic t_reset;
    chk("R1", "valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "hit after reset", 32'(rsp_hit), 32'd0);
    chk("R1", "addr after reset", 32'(rsp_addr), 32'd0);
    look("R1", 32'h1000_0ABC, 1'b0, 1'b0, 30'h0, 1'b0);
    look("R1", 32'h0000_0000, 1'b1, 1'b0, 30'h0, 1'b0);
  endtask

  task automatic t_single;
    stage(1'b0, 1'b1, 1'b1, 4'd0);
    commit(8'd0, 16'h0123, 16'h4000);
    look("R6", 32'h1000_0ABC, 1'b0, 1'b1, 30'h048_CABC, 1'b0);
    look("R4", 32'h1000_4000, 1'b0, 1'b0, 30'h0, 1'b0);
    look("R4", 32'hD000_0ABC, 1'b1, 1'b1, 30'h048_CABC, 1'b0);
    @(negedge clk);
    chk("R10", "valid drops", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_run;
    stage(1'b0, 1'b1, 1'b1, 4'd4);
    commit(8'd5, 16'h0200, 16'h4010);
    look("R6", 32'h1007_C010, 1'b1, 1'b1, 30'h083_C010, 1'b0);
    look("R6", 32'h1004_0000, 1'b0, 1'b1, 30'h080_0000, 1'b0);
    look("R4", 32'h1008_0000, 1'b0, 1'b0, 30'h0, 1'b0);
  endtask

  task automatic t_types;
    stage(1'b0, 1'b1, 1'b0, 4'd0);
    commit(8'd7, 16'h0777, 16'h0100);
    stage(1'b0, 1'b0, 1'b1, 4'd0);
    commit(8'd8, 16'h0010, 16'h0101);
    look("R5", 32'h0040_0000, 1'b0, 1'b1, 30'h1DD_C000, 1'b0);
    look("R5", 32'h0040_0000, 1'b1, 1'b0, 30'h0, 1'b0);
    look("R5", 32'h0040_4000, 1'b1, 1'b1, 30'h004_0000, 1'b0);
    look("R5", 32'h0040_4000, 1'b0, 1'b0, 30'h0, 1'b0);
  endtask

  task automatic t_iv;
    stage(1'b1, 1'b1, 1'b1, 4'd0);
    commit(8'd9, 16'h0000, 16'h3FFF);
    look("R8", 32'h0FFF_C000, 1'b1, 1'b1, 30'h0, 1'b1);
  endtask

  task automatic t_priority;
    stage(1'b0, 1'b1, 1'b1, 4'd0);
    commit(8'd3, 16'h0AAA, 16'h0200);
    commit(8'd1, 16'h0555, 16'h0200);
    look("R7", 32'h0080_0004, 1'b0, 1'b1, 30'h155_4004, 1'b0);
    stage(1'b0, 1'b0, 1'b0, 4'd0);
    commit(8'd1, 16'h0555, 16'h0200);
    look("R3", 32'h0080_0004, 1'b0, 1'b1, 30'h2AA_8004, 1'b0);
  endtask

  task automatic t_bad_idx;
    stage(1'b0, 1'b1, 1'b1, 4'd0);
    commit(8'd192, 16'h0001, 16'h0300);
    look("R3", 32'h00C0_0000, 1'b0, 1'b0, 30'h0, 1'b0);
  endtask

  task automatic t_stage_only;
    stage(1'b1, 1'b0, 1'b0, 4'd3);
    look("R2", 32'h1000_0ABC, 1'b0, 1'b1, 30'h048_CABC, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_run();
    t_types();
    t_iv();
    t_priority();
    t_bad_idx();
    t_stage_only();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule